// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the host-facing register file of an I2C master. A host reaches it through a plain 32-bit read/write port with byte addresses. A separate bit engine consumes command words from a transmit queue and returns received bytes into a receive queue. The block holds both queues, a status word, a control word and two clock-divider registers for the engine. It also folds the status conditions, each gated by its own enable, into a single interrupt line.

The transmit queue and the receive queue share address 0x00. A write there pushes a 10-bit command word: bits 7:0 carry data, bit 8 asks for a start and bit 9 asks for a stop. A read there pops one received byte. The completion and lost-arbitration flags are sticky and are cleared by writing 1 to them. A self-clearing soft reset, set through the control word, empties both queues, clears the sticky flags and holds the engine in reset for a fixed number of cycles.

Top module: `i2c_regblock`

## Requirements
- R1: After reset, status (0x04) reads 0xA00 when the bus inputs are low, meaning receive-empty (bit 9) and transmit-empty (bit 11). Control (0x08) and both levels (0x18, 0x1C) read 0, and `irq` is low.
- R2: A write to 0x00 pushes `reg_wdata[9:0]` into the transmit queue. The engine sees the words on `tx_word` in write order while `tx_valid` is high, and each `tx_pop` removes the head. Address 0x1C reads the entry count.
- R3: The transmit queue holds DEPTH (4) words. When it is full, status bit 10 is set and a further host write to 0x00 changes neither the contents nor the level.
- R4: `rx_push` stores `rx_byte` unless the receive queue is full. A read of 0x00 returns the head byte in bits 7:0 and pops it. Address 0x18 reads the count, and status bit 8 flags full. A read of an empty receive queue returns 0 and changes nothing.
- R5: Status bits 0 (done) and 1 (arbitration lost) are set by pulses on `ev_done` and `ev_arb_lost`. They stay set until the host writes 1 to the same bit of 0x04. Writing 0 to them has no effect.
- R6: Status bit 2 (no-ack) is set by `ev_nack` and is not cleared by writes to 0x04. Status bits 3, 5, 6 and 7 follow `data_req`, `bus_active`, `scl_in` and `sda_in`.
- R7: `irq` is high exactly when any enabled source is true. The control-bit to source pairs are: 0 done, 1 arbitration lost, 2 no-ack, 3 `data_req`, 4 `slave_req`, 5 receive full, 6 receive not empty, 7 transmit full.
- R8: Writing 1 to control bit 8 starts a soft reset. Bit 8 and `eng_reset` then read 1 for RST_CYCLES (4) cycles before clearing themselves. The reset empties both queues and clears status bits 0 to 2. Queue pushes made during it are dropped, and control bits 7:0 keep their written value.
- R9: Addresses 0x0C and 0x10 are 10-bit read/write dividers driving `scl_lo_div` and `scl_hi_div`. They reset to 98, and bits above 9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (pops on 0x00) |
| reg_addr | input | 8 | Host byte address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_word | output | 10 | Head command word |
| tx_pop | input | 1 | Engine consumes head word |
| rx_push | input | 1 | Engine delivers a byte |
| rx_byte | input | 8 | Received byte |
| ev_done | input | 1 | Transfer-done pulse |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| data_req | input | 1 | Engine needs transmit data (level) |
| slave_req | input | 1 | Slave-side data request (level) |
| bus_active | input | 1 | Bus busy |
| scl_in | input | 1 | Sampled SCL |
| sda_in | input | 1 | Sampled SDA |
| eng_reset | output | 1 | Engine reset while soft reset runs |
| scl_lo_div | output | 10 | SCL low-phase divider |
| scl_hi_div | output | 10 | SCL high-phase divider |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences overfill the transmit queue, read the receive queue when it is empty, and pulse each event next to writes of 0 and of 1 to status. These expose a wrong full or empty guard and confuse a write-1-to-clear flag with a plain writable one. Each enable is then raised alone against one active source, so a swapped bit in the interrupt mapping shows up. A soft reset is issued with both queues loaded and a push made inside its window, which checks the flush, the duration and the dropped push. A seeded random mix of host pushes, engine pops, engine pushes and host pops then runs against queue models in the bench. It tells ordering and pointer-wrap errors apart from simple level-count errors.

// File: rtl/i2c_regblock.sv
`timescale 1ns/1ps
module i2c_regblock #(
  parameter int DEPTH = 4,
  parameter int RST_CYCLES = 4,
  parameter logic [9:0] DIV_RST = 10'd98
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  output logic [9:0]  tx_word,
  input  logic        tx_pop,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        ev_done,
  input  logic        ev_arb_lost,
  input  logic        ev_nack,
  input  logic        data_req,
  input  logic        slave_req,
  input  logic        bus_active,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        eng_reset,
  output logic [9:0]  scl_lo_div,
  output logic [9:0]  scl_hi_div,
  output logic        irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [9:0] txq [DEPTH];
  logic [7:0] rxq [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0] ctl_q;
  logic busy;
  logic [RW-1:0] rcnt;
  logic f_done, f_arb, f_nack;
  logic [9:0] div_lo, div_hi;
  wire unused_wdata = &{1'b0, reg_wdata[31:10]};

  wire sel_fifo = reg_addr == 8'h00;
  wire sel_st   = reg_addr == 8'h04;
  wire sel_ctl  = reg_addr == 8'h08;
  wire sel_lo   = reg_addr == 8'h0C;
  wire sel_hi   = reg_addr == 8'h10;

  wire tx_full  = tx_cnt == FULL_CNT;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL_CNT;
  wire rx_empty = rx_cnt == '0;

  wire tx_in  = reg_wr && sel_fifo && !busy && !tx_full;
  wire tx_out = tx_pop && !busy && !tx_empty;
  wire rx_in  = rx_push && !busy && !rx_full;
  wire rx_out = reg_rd && sel_fifo && !busy && !rx_empty;
  wire st_wr  = reg_wr && sel_st;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (busy) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in) tx_wp <= nxt(tx_wp);
      if (tx_out) tx_rp <= nxt(tx_rp);
      if (tx_in && !tx_out) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_in && tx_out) tx_cnt <= tx_cnt - 1'b1;
    end

  always_ff @(posedge clk)
    if (tx_in) txq[tx_wp] <= reg_wdata[9:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (busy) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in) rx_wp <= nxt(rx_wp);
      if (rx_out) rx_rp <= nxt(rx_rp);
      if (rx_in && !rx_out) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_in && rx_out) rx_cnt <= rx_cnt - 1'b1;
    end

  always_ff @(posedge clk)
    if (rx_in) rxq[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0; busy <= 1'b0; rcnt <= '0;
    end else begin
      if (reg_wr && sel_ctl) ctl_q <= reg_wdata[7:0];
      if (busy) begin
        if (rcnt == '0) busy <= 1'b0;
        else rcnt <= rcnt - 1'b1;
      end else if (reg_wr && sel_ctl && reg_wdata[8]) begin
        busy <= 1'b1;
        rcnt <= RW'(RST_CYCLES - 1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      f_done <= 1'b0; f_arb <= 1'b0; f_nack <= 1'b0;
    end else if (busy) begin
      f_done <= 1'b0; f_arb <= 1'b0; f_nack <= 1'b0;
    end else begin
      if (ev_done) f_done <= 1'b1;
      else if (st_wr && reg_wdata[0]) f_done <= 1'b0;
      if (ev_arb_lost) f_arb <= 1'b1;
      else if (st_wr && reg_wdata[1]) f_arb <= 1'b0;
      if (ev_nack) f_nack <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_lo <= DIV_RST; div_hi <= DIV_RST;
    end else if (reg_wr) begin
      if (sel_lo) div_lo <= reg_wdata[9:0];
      if (sel_hi) div_hi <= reg_wdata[9:0];
    end

  wire [31:0] status = {20'b0, tx_empty, tx_full, rx_empty, rx_full,
                        sda_in, scl_in, bus_active, 1'b0,
                        data_req, f_nack, f_arb, f_done};
  wire [7:0] src = {tx_full, !rx_empty, rx_full, slave_req,
                    data_req, f_nack, f_arb, f_done};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00: reg_rdata[7:0] = rx_empty ? 8'h00 : rxq[rx_rp];
      8'h04: reg_rdata = status;
      8'h08: reg_rdata[8:0] = {busy, ctl_q};
      8'h0C: reg_rdata[9:0] = div_lo;
      8'h10: reg_rdata[9:0] = div_hi;
      8'h18: reg_rdata[CW-1:0] = rx_cnt;
      8'h1C: reg_rdata[CW-1:0] = tx_cnt;
      default: reg_rdata = '0;
    endcase
  end

  assign tx_valid   = !tx_empty;
  assign tx_word    = txq[tx_rp];
  assign eng_reset  = busy;
  assign scl_lo_div = div_lo;
  assign scl_hi_div = div_hi;
  assign irq        = |(src & ctl_q);

  // R3
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel_fifo && tx_full && !tx_pop) |=> $stable(tx_cnt));
  // R4
  rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fifo && rx_empty) |-> reg_rdata == 32'h0);
  // R8
  srst_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_reset) |=> (tx_cnt == '0 && rx_cnt == '0 && !f_nack));
  // R5
  done_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[0] && !ev_done) |=> !f_done);
  // R7
  irq_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[6] && rx_cnt != '0) |-> irq);
endmodule

// File: tb/tb_i2c_regblock.sv
`timescale 1ns/1ps
module tb_i2c_regblock;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_pop = 0, rx_push = 0;
  logic [9:0] tx_word;
  logic [7:0] rx_byte = 0;
  logic ev_done = 0, ev_arb_lost = 0, ev_nack = 0, data_req = 0, slave_req = 0;
  logic bus_active = 0, scl_in = 0, sda_in = 0;
  logic eng_reset, irq;
  logic [9:0] scl_lo_div, scl_hi_div;
  int tests = 0, fails = 0;
  logic [9:0] mtx[$];
  logic [7:0] mrx[$];
  logic [31:0] rv;

  always #5 clk = ~clk;

  i2c_regblock dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic epop();
    @(negedge clk); tx_pop = 1; @(posedge clk); #1 tx_pop = 0;
  endtask

  task automatic epush(input logic [7:0] b);
    @(negedge clk); rx_push = 1; rx_byte = b; @(posedge clk); #1 rx_push = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ev_done = 1; 1: ev_arb_lost = 1; default: ev_nack = 1; endcase
    @(posedge clk); #1 ev_done = 0; ev_arb_lost = 0; ev_nack = 0;
  endtask

  function automatic logic [7:0] exp_rx(input int n);
    return (n == 0) ? 8'h00 : mrx[0];
  endfunction

  initial begin
    #1_900_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [9:0] words [5];
    void'($urandom(32'd1234));
    words = '{10'h101, 10'h0A2, 10'h2C3, 10'h3E4, 10'h155};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(8'h04, rv); chk("R1 status", rv, 32'hA00);
    rd(8'h08, rv); chk("R1 ctl", rv, 0);
    rd(8'h18, rv); chk("R1 rxlvl", rv, 0);
    rd(8'h1C, rv); chk("R1 txlvl", rv, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(8'h0C, rv); chk("R9 lo reset", rv, 98);
    wr(8'h0C, 32'hFFFF); wr(8'h10, 32'h0123);
    rd(8'h0C, rv); chk("R9 lo mask", rv, 32'h3FF);
    rd(8'h10, rv); chk("R9 hi", rv, 32'h123);
    chk("R9 pins", {12'b0, scl_lo_div, scl_hi_div}, {12'b0, 10'h3FF, 10'h123});

    for (int i = 0; i < 5; i++) wr(8'h00, {22'b0, words[i]});
    rd(8'h1C, rv); chk("R3 txlvl full", rv, 4);
    rd(8'h04, rv); chk("R3 tx full bit10", rv[10], 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R2 tx order", {22'b0, tx_word}, {22'b0, words[i]});
      epop();
    end
    chk("R2 tx drained", {31'b0, tx_valid}, 0);

    rd(8'h00, rv); chk("R4 empty read", rv, 0);
    rd(8'h18, rv); chk("R4 empty lvl", rv, 0);
    epush(8'h5A); epush(8'hC3); epush(8'h01); epush(8'hFE); epush(8'h77);
    rd(8'h04, rv); chk("R4 rx full bit8", rv[8], 1);
    rd(8'h00, rv); chk("R4 rx b0", rv, 32'h5A);
    rd(8'h00, rv); chk("R4 rx b1", rv, 32'hC3);
    rd(8'h18, rv); chk("R4 rx lvl", rv, 2);
    rd(8'h00, rv); rd(8'h00, rv); chk("R4 rx b3", rv, 32'hFE);

    pulse(0); rd(8'h04, rv); chk("R5 done set", rv[0], 1);
    wr(8'h04, 32'h0); rd(8'h04, rv); chk("R5 done keep", rv[0], 1);
    wr(8'h04, 32'h1); rd(8'h04, rv); chk("R5 done clr", rv[0], 0);
    pulse(1); rd(8'h04, rv); chk("R5 arb set", rv[1], 1);
    wr(8'h04, 32'h2); rd(8'h04, rv); chk("R5 arb clr", rv[1], 0);

    pulse(2); wr(8'h04, 32'h7); rd(8'h04, rv); chk("R6 nack sticky", rv[2], 1);
    @(negedge clk); data_req = 1; bus_active = 1; scl_in = 1; sda_in = 1;
    rd(8'h04, rv); chk("R6 inputs", rv[7:0], 8'hEC);
    @(negedge clk); data_req = 0; bus_active = 0; scl_in = 0; sda_in = 0;

    wr(8'h08, 32'h04); @(negedge clk); chk("R7 nack irq", {31'b0, irq}, 1);
    wr(8'h08, 32'h03); @(negedge clk); chk("R7 off irq", {31'b0, irq}, 0);
    wr(8'h08, 32'h10); @(negedge clk); slave_req = 1; #1;
    chk("R7 slave irq", {31'b0, irq}, 1);
    slave_req = 0;
    epush(8'h33);
    wr(8'h08, 32'h40); @(negedge clk); chk("R7 avail irq", {31'b0, irq}, 1);
    wr(8'h08, 32'h20); @(negedge clk); chk("R7 rxfull off", {31'b0, irq}, 0);

    wr(8'h00, 32'h12); wr(8'h00, 32'h34);
    wr(8'h08, 32'h1A0);
    rd(8'h08, rv); chk("R8 busy", rv, 32'h1A0);
    chk("R8 eng_reset", {31'b0, eng_reset}, 1);
    wr(8'h00, 32'h99);
    repeat (5) @(posedge clk);
    rd(8'h08, rv); chk("R8 selfclear", rv, 32'h0A0);
    rd(8'h1C, rv); chk("R8 tx flushed", rv, 0);
    rd(8'h18, rv); chk("R8 rx flushed", rv, 0);
    rd(8'h04, rv); chk("R8 flags", rv[2:0], 0);
    wr(8'h08, 32'h0);

    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 3);
      case (op)
        0: begin
          logic [9:0] w;
          w = 10'($urandom);
          wr(8'h00, {22'b0, w});
          if (mtx.size() < 4) mtx.push_back(w);
        end
        1: begin
          @(negedge clk); #1;
          chk("R2 rnd valid", {31'b0, tx_valid}, {31'b0, mtx.size() != 0});
          if (mtx.size() != 0) chk("R2 rnd head", {22'b0, tx_word}, {22'b0, mtx[0]});
          epop();
          if (mtx.size() != 0) void'(mtx.pop_front());
        end
        2: begin
          logic [7:0] b;
          b = 8'($urandom);
          epush(b);
          if (mrx.size() < 4) mrx.push_back(b);
        end
        default: begin
          rd(8'h00, rv);
          chk("R4 rnd read", rv, {24'b0, exp_rx(mrx.size())});
          if (mrx.size() != 0) void'(mrx.pop_front());
        end
      endcase
      if (it % 20 == 19) begin
        rd(8'h1C, rv); chk("R3 rnd txlvl", rv, mtx.size());
        rd(8'h18, rv); chk("R4 rnd rxlvl", rv, mrx.size());
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule